// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of a parallel NOR flash bus and expands one high-level request into the exact train of bus write cycles the flash expects. A request carries a 4-bit operation code, a target address, a data word and a byte/word bus-width bit. The sequencer emits one single-cycle write strobe per step, with a fixed, parameterised number of idle clocks between strobes. After the last strobe it raises a one-cycle completion pulse. Polling for the end of an erase or program, and array reads, are left to other logic.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The operation code, address, data and bus-width bit are captured on that edge. The requester must hold its request stable until it is taken. `req_ready` drops on the cycle after acceptance and stays low until the last write of the sequence has been driven, so any request presented meanwhile simply waits. The bus side has no back-pressure: every write strobe lasts exactly one clock.

The sequencer tracks two modes of the flash. The first is unlock-bypass, entered and left through its own operations. The second is erase-suspend. It refuses a bypass program outside unlock-bypass, a resume without a prior suspend, and any unknown operation code. A refused request produces no bus activity. It finishes with a completion pulse that carries an error flag.

Top module: `nor_cmd_seq`

## Requirements
- R1: Operation codes: 0 reset, 1 read-ID, 2 program, 3 bypass entry, 4 bypass program, 5 bypass exit, 6 chip erase, 7 sector erase, 8 suspend, 9 resume. A request is taken only when `req_ready` is high, and `req_ready` is low from the cycle after acceptance through the cycle of the last write. A request presented while `req_ready` is low is not taken until `req_ready` returns.
- R2: The first unlock address is 555h in word mode (`byte_mode`=0) and AAAh in byte mode. The second unlock address is 2AAh in word mode and 555h in byte mode. The value of `byte_mode` sampled at acceptance governs the whole sequence.
- R3: Program issues four writes: AAh to the first unlock address, 55h to the second, A0h to the first, then the request data to the request address. In byte mode, data bits 15:8 of that last write are zero.
- R4: Chip erase and sector erase each issue six writes: AAh, 55h, 80h, AAh and 55h on the unlock addresses. The sixth write is 10h to the first unlock address for chip erase, or 30h to the request address for sector erase.
- R5: Bypass entry issues AAh, 55h, then 20h to the first unlock address, and sets bypass mode. Bypass exit issues 90h then 00h, both to address 0, and clears bypass mode.
- R6: Bypass program issues A0h to address 0, then the request data to the request address. It is refused unless bypass mode is set.
- R7: Reset, suspend and resume each issue a single write to address 0, with data F0h, B0h and 30h respectively. A completed suspend sets the suspended mode and a completed resume clears it. A resume is refused unless the suspended mode is set.
- R8: Read-ID issues AAh, 55h, then 90h to the first unlock address.
- R9: Exactly GAP idle cycles separate consecutive writes of one sequence, and the first write is driven in the cycle after acceptance. `busy` is high from the cycle after acceptance through the last write. Outside a write, `bus_addr` and `bus_data` are zero, and command writes drive data bits 15:8 as zero.
- R10: `done` pulses for one cycle right after the last write. A refused request (including codes 10 to 15) causes no write, leaves `busy` low, and raises `done` and `err` together in the cycle after acceptance.
- R11: After reset, `busy`, `bus_we`, `done` and `err` are low, `req_ready` is high, and neither mode is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 selects byte-wide bus addressing |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Program or sector address |
| req_data | input | DATA_W | Program data |
| bus_we | output | 1 | One-cycle write strobe |
| bus_addr | output | ADDR_W | Write address |
| bus_data | output | DATA_W | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished or refused |
| err | output | 1 | Request was refused (with done) |

## Verification
A mode change and a legality check can fall on adjacent edges. Bypass mode or suspended mode is updated on the edge of the final write, and a request held pending behind that sequence is judged against the new mode on the very next edge. The bench provokes this by keeping a bypass program or a resume asserted throughout the entry or suspend sequence. It also provokes it in reverse, by queuing a bypass program behind a bypass exit. A cycle-by-cycle model decides, for every clock, whether that pending request is accepted with writes or refused with an error, and compares the result.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam int MAX_STEPS = 6;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);

  typedef enum logic [3:0] {
    OP_RESET      = 4'd0,
    OP_READ_ID    = 4'd1,
    OP_PROGRAM    = 4'd2,
    OP_BYP_ENTER  = 4'd3,
    OP_BYP_PROG   = 4'd4,
    OP_BYP_EXIT   = 4'd5,
    OP_CHIP_ERASE = 4'd6,
    OP_SECT_ERASE = 4'd7,
    OP_SUSPEND    = 4'd8,
    OP_RESUME     = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    AD_ZERO,
    AD_UNLK1,
    AD_UNLK2,
    AD_TARGET
  } addr_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WRITE,
    PH_GAP
  } phase_e;
endpackage

// File: rtl/nor_seq_table.sv
module nor_seq_table
  import nor_seq_pkg::*;
(
  input  logic [3:0]        op,
  input  logic [STEP_W-1:0] idx,
  output logic [STEP_W-1:0] len,
  output addr_sel_e         sel,
  output logic [7:0]        cmd,
  output logic              payload,
  output logic              known
);
  // two-write unlock prefix shared by several sequences
  logic [7:0] pre_cmd;
  addr_sel_e  pre_sel;
  logic       second;

  always_comb begin
    second  = (idx == STEP_W'(1)) || (idx == STEP_W'(4));
    pre_cmd = second ? 8'h55 : 8'hAA;
    pre_sel = second ? AD_UNLK2 : AD_UNLK1;
  end

  always_comb begin
    len     = STEP_W'(1);
    sel     = AD_ZERO;
    cmd     = 8'h00;
    payload = 1'b0;
    known   = 1'b1;
    case (op)
      OP_RESET:   cmd = 8'hF0;
      OP_SUSPEND: cmd = 8'hB0;
      OP_RESUME:  cmd = 8'h30;
      OP_READ_ID, OP_BYP_ENTER: begin
        len = STEP_W'(3);
        if (idx == STEP_W'(2)) begin
          sel = AD_UNLK1;
          cmd = (op == OP_READ_ID) ? 8'h90 : 8'h20;
        end else begin
          sel = pre_sel;
          cmd = pre_cmd;
        end
      end
      OP_PROGRAM: begin
        len = STEP_W'(4);
        if (idx == STEP_W'(3)) begin
          sel     = AD_TARGET;
          payload = 1'b1;
        end else if (idx == STEP_W'(2)) begin
          sel = AD_UNLK1;
          cmd = 8'hA0;
        end else begin
          sel = pre_sel;
          cmd = pre_cmd;
        end
      end
      OP_BYP_PROG: begin
        len = STEP_W'(2);
        if (idx == STEP_W'(1)) begin
          sel     = AD_TARGET;
          payload = 1'b1;
        end else begin
          cmd = 8'hA0;
        end
      end
      OP_BYP_EXIT: begin
        len = STEP_W'(2);
        cmd = (idx == STEP_W'(0)) ? 8'h90 : 8'h00;
      end
      OP_CHIP_ERASE, OP_SECT_ERASE: begin
        len = STEP_W'(6);
        if (idx == STEP_W'(5)) begin
          sel = (op == OP_SECT_ERASE) ? AD_TARGET : AD_UNLK1;
          cmd = (op == OP_SECT_ERASE) ? 8'h30 : 8'h10;
        end else if (idx == STEP_W'(2)) begin
          sel = AD_UNLK1;
          cmd = 8'h80;
        end else begin
          sel = pre_sel;
          cmd = pre_cmd;
        end
      end
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/nor_seq_pacer.sv
module nor_seq_pacer
  import nor_seq_pkg::*;
#(
  parameter int GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STEP_W-1:0] len,
  output logic              we,
  output logic              busy,
  output logic [STEP_W-1:0] idx,
  output logic              finish
);
  localparam int CNT_W = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'((GAP > 0) ? GAP - 1 : 0);

  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic [STEP_W-1:0] len_q;

  assign we     = (phase == PH_WRITE);
  assign busy   = (phase != PH_IDLE);
  assign finish = we && ((idx + STEP_W'(1)) == len_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      idx   <= '0;
      len_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_WRITE;
          idx   <= '0;
          len_q <= len;
        end
        PH_WRITE: begin
          if (finish) begin
            phase <= PH_IDLE;
          end else if (GAP == 0) begin
            idx <= idx + STEP_W'(1);
          end else begin
            phase <= PH_GAP;
            cnt   <= CNT_LOAD;
          end
        end
        PH_GAP: begin
          if (cnt == '0) begin
            phase <= PH_WRITE;
            idx   <= idx + STEP_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R9: a strobe is never followed directly by another one when a gap exists
  generate
    if (GAP > 0) begin : g_gap_chk
      a_r9_idle_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);
    end
  endgenerate

  a_r9_start_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (we && idx == '0));

  a_r9_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (idx < len_q));
endmodule

// File: rtl/nor_seq_mode.sv
module nor_seq_mode
  import nor_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       finish,
  input  logic [3:0] op,
  output logic       bypass,
  output logic       suspended
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bypass    <= 1'b0;
      suspended <= 1'b0;
    end else if (finish) begin
      if (op == OP_BYP_ENTER) bypass <= 1'b1;
      if (op == OP_BYP_EXIT)  bypass <= 1'b0;
      if (op == OP_SUSPEND)   suspended <= 1'b1;
      if (op == OP_RESUME)    suspended <= 1'b0;
    end
  end

  // R5 / R7: modes move only when a sequence completes
  a_r5_bypass_moves_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass != $past(bypass)) |-> $past(finish));

  a_r7_suspend_moves_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended != $past(suspended)) |-> $past(finish));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int GAP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam logic [ADDR_W-1:0] WORD_U1 = ADDR_W'('h555);
  localparam logic [ADDR_W-1:0] WORD_U2 = ADDR_W'('h2AA);
  localparam logic [ADDR_W-1:0] BYTE_U1 = ADDR_W'('hAAA);
  localparam logic [ADDR_W-1:0] BYTE_U2 = ADDR_W'('h555);

  logic [3:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              byte_q;

  logic              pace_busy, pace_we, finish;
  logic [STEP_W-1:0] idx, tbl_idx, tbl_len;
  logic [3:0]        tbl_op;
  addr_sel_e         sel;
  logic [7:0]        cmd;
  logic              payload, known;
  logic              bypass, suspended;
  logic              accept, refused, start;

  assign req_ready = !pace_busy;
  assign busy      = pace_busy;
  assign accept    = req_valid && req_ready;
  assign tbl_op    = pace_busy ? op_q : req_op;
  assign tbl_idx   = pace_busy ? idx  : '0;

  nor_seq_table u_table (
    .op      (tbl_op),
    .idx     (tbl_idx),
    .len     (tbl_len),
    .sel     (sel),
    .cmd     (cmd),
    .payload (payload),
    .known   (known)
  );

  always_comb begin
    refused = !known
           || (req_op == OP_BYP_PROG && !bypass)
           || (req_op == OP_RESUME   && !suspended);
    start   = accept && !refused;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      byte_q <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (start) begin
        op_q   <= req_op;
        addr_q <= req_addr;
        data_q <= req_data;
        byte_q <= byte_mode;
      end
      done <= finish || (accept && refused);
      err  <= accept && refused;
    end
  end

  nor_seq_pacer #(.GAP(GAP)) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .len    (tbl_len),
    .we     (pace_we),
    .busy   (pace_busy),
    .idx    (idx),
    .finish (finish)
  );

  nor_seq_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .finish    (finish),
    .op        (op_q),
    .bypass    (bypass),
    .suspended (suspended)
  );

  always_comb begin
    bus_we   = pace_we;
    bus_addr = '0;
    bus_data = '0;
    if (pace_we) begin
      case (sel)
        AD_UNLK1:  bus_addr = byte_q ? BYTE_U1 : WORD_U1;
        AD_UNLK2:  bus_addr = byte_q ? BYTE_U2 : WORD_U2;
        AD_TARGET: bus_addr = addr_q;
        default:   bus_addr = '0;
      endcase
      if (payload) bus_data = byte_q ? DATA_W'(data_q[7:0]) : data_q;
      else         bus_data = DATA_W'(cmd);
    end
  end

  // R10: refusals produce a flagged completion and no sequence
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r6_bypass_prog_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == OP_BYP_PROG && !bypass) |=> (err && !busy && !bus_we));

  a_r7_resume_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == OP_RESUME && !suspended) |=> (err && !busy && !bus_we));

  a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ($past(bus_we) && !busy));

  a_r1_busy_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));
endmodule

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 2;
  localparam int ADDR_W     = 20;
  localparam int DATA_W     = 16;
  localparam int MAX_CYC    = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_mode = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [3:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic bus_we, busy, done, err;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GAP(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_data(bus_data),
    .busy(busy), .done(done), .err(err)
  );

  typedef struct { int a; int d; } wr_t;

  // behavioural reference model
  wr_t mq[$];
  wr_t cap[$];
  int  m_phase = 0;   // 0 idle, 1 writing, 2 gap
  int  m_gap = 0, m_op = 0;
  bit  m_byp = 0, m_sus = 0, m_done = 0, m_err = 0, m_acc = 0;
  int  nchk = 0, nerr = 0, cyc = 0;
  bit  wd = 0;

  function automatic string tag_of(int op);
    case (op)
      1: return "R8";
      2: return "R3";
      3, 5: return "R5";
      4: return "R6";
      6, 7: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic build(int op, int ad, int da, bit bm);
    int u1 = bm ? 'hAAA : 'h555;
    int u2 = bm ? 'h555 : 'h2AA;
    int pd = bm ? (da & 'hFF) : da;
    case (op)
      0: mq.push_back('{0, 'hF0});
      8: mq.push_back('{0, 'hB0});
      9: mq.push_back('{0, 'h30});
      1, 2, 3: begin
        mq.push_back('{u1, 'hAA}); mq.push_back('{u2, 'h55});
        if (op == 1) mq.push_back('{u1, 'h90});
        if (op == 3) mq.push_back('{u1, 'h20});
        if (op == 2) begin mq.push_back('{u1, 'hA0}); mq.push_back('{ad, pd}); end
      end
      4: begin mq.push_back('{0, 'hA0}); mq.push_back('{ad, pd}); end
      5: begin mq.push_back('{0, 'h90}); mq.push_back('{0, 'h00}); end
      default: begin
        mq.push_back('{u1, 'hAA}); mq.push_back('{u2, 'h55});
        mq.push_back('{u1, 'h80});
        mq.push_back('{u1, 'hAA}); mq.push_back('{u2, 'h55});
        if (op == 6) mq.push_back('{u1, 'h10});
        else         mq.push_back('{ad, 'h30});
      end
    endcase
  endtask

  task automatic model_step(bit v, int op, int ad, int da, bit bm);
    m_acc = 0; m_done = 0; m_err = 0;
    case (m_phase)
      1: begin
        void'(mq.pop_front());
        if (mq.size() == 0) begin
          m_phase = 0; m_done = 1;
          if (m_op == 3) m_byp = 1;
          if (m_op == 5) m_byp = 0;
          if (m_op == 8) m_sus = 1;
          if (m_op == 9) m_sus = 0;
        end else if (GAP == 0) m_phase = 1;
        else begin m_phase = 2; m_gap = GAP; end
      end
      2: begin
        m_gap--;
        if (m_gap == 0) m_phase = 1;
      end
      default: if (v) begin
        m_acc = 1;
        if (op > 9 || (op == 4 && !m_byp) || (op == 9 && !m_sus)) begin
          m_done = 1; m_err = 1;
        end else begin
          build(op, ad, da, bm);
          m_op = op; m_phase = 1;
        end
      end
    endcase
  endtask

  task automatic compare();
    bit ew = (m_phase == 1);
    int ea = ew ? mq[0].a : 0;
    int ed = ew ? mq[0].d : 0;
    string wt = ew ? tag_of(m_op) : "R9";
    chk(bus_we == ew, "R9", "bus_we", int'(bus_we), int'(ew));
    chk(int'(bus_addr) == ea, wt, "bus_addr", int'(bus_addr), ea);
    chk(int'(bus_data) == ed, wt, "bus_data", int'(bus_data), ed);
    chk(busy == (m_phase != 0), "R9", "busy", int'(busy), int'(m_phase != 0));
    chk(req_ready == (m_phase == 0), "R1", "req_ready", int'(req_ready), int'(m_phase == 0));
    chk(done == m_done, "R10", "done", int'(done), int'(m_done));
    chk(err == m_err, "R10", "err", int'(err), int'(m_err));
  endtask

  task automatic tick();
    bit v = req_valid;
    int op = int'(req_op), ad = int'(req_addr), da = int'(req_data);
    bit bm = byte_mode;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (cyc > MAX_CYC && !wd) begin
      wd = 1; nerr++;
      $display("FAIL R1 watchdog actual=%0d expected<=%0d", cyc, MAX_CYC);
    end
    model_step(v, op, ad, da, bm);
    compare();
    if (bus_we) cap.push_back('{int'(bus_addr), int'(bus_data)});
  endtask

  task automatic settle();
    while (!wd && !(m_phase == 0 && m_done)) tick();
    tick();
  endtask

  task automatic run(int op, int ad, int da, bit bm);
    cap.delete();
    req_op = 4'(op); req_addr = ADDR_W'(ad); req_data = DATA_W'(da);
    byte_mode = bm; req_valid = 1'b1;
    do tick(); while (!m_acc && !wd);
    req_valid = 1'b0;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    chk(busy == 0 && bus_we == 0, "R11", "busy/we", int'({busy, bus_we}), 0);
    chk(done == 0 && err == 0, "R11", "done/err", int'({done, err}), 0);
    chk(req_ready == 1, "R11", "req_ready", int'(req_ready), 1);
    tick();

    run(0, 0, 0, 0);                       // R7 reset command
    chk(cap.size() == 1 && cap[0].d == 'hF0, "R7", "reset write", cap.size(), 1);
    run(1, 0, 0, 0);                       // R8 read-ID
    chk(cap.size() == 3 && cap[2].d == 'h90, "R8", "id writes", cap.size(), 3);
    run(2, 'h12345, 'hBEEF, 0);            // R3 program, word
    chk(cap.size() == 4, "R3", "program count", cap.size(), 4);
    chk(cap[0].a == 'h555 && cap[1].a == 'h2AA, "R2", "word unlock", cap[0].a, 'h555);
    chk(cap[3].d == 'hBEEF, "R3", "word data", cap[3].d, 'hBEEF);
    run(2, 'h00321, 'hBEEF, 1);            // byte mode
    chk(cap[0].a == 'hAAA && cap[1].a == 'h555, "R2", "byte unlock", cap[0].a, 'hAAA);
    chk(cap[3].d == 'h00EF, "R3", "byte data upper zero", cap[3].d, 'h00EF);
    run(4, 'h40, 'h1234, 0);               // R6 refused outside bypass
    chk(cap.size() == 0, "R6", "refused writes", cap.size(), 0);

    // R1 / R6: bypass program held pending behind bypass entry
    cap.delete();
    req_op = 4'd3; req_valid = 1'b1; byte_mode = 1'b0;
    do tick(); while (!m_acc && !wd);
    req_op = 4'd4; req_addr = 'h777; req_data = 'hA5A5;
    do tick(); while (!m_acc && !wd);
    req_valid = 1'b0;
    settle();
    chk(cap.size() == 5, "R1", "entry then bypass program", cap.size(), 5);
    chk(cap[2].d == 'h20 && cap[4].d == 'hA5A5, "R6", "bypass program data", cap[4].d, 'hA5A5);

    // R5: bypass program queued behind bypass exit must be refused
    cap.delete();
    req_op = 4'd5; req_valid = 1'b1;
    do tick(); while (!m_acc && !wd);
    req_op = 4'd4;
    do tick(); while (!m_acc && !wd);
    req_valid = 1'b0;
    settle();
    chk(cap.size() == 2 && cap[1].d == 0, "R5", "exit writes", cap.size(), 2);

    run(6, 0, 0, 0);                       // R4 chip erase
    chk(cap.size() == 6 && cap[5].d == 'h10 && cap[5].a == 'h555, "R4", "chip erase", cap[5].d, 'h10);
    run(7, 'h3F000, 0, 1);                 // R4 sector erase, byte mode
    chk(cap.size() == 6 && cap[5].a == 'h3F000 && cap[3].a == 'hAAA, "R4", "sector erase", cap[5].a, 'h3F000);
    run(9, 0, 0, 0);                       // R7 resume refused
    chk(cap.size() == 0, "R7", "resume refused", cap.size(), 0);

    // R7: resume held pending behind suspend
    cap.delete();
    req_op = 4'd8; req_valid = 1'b1;
    do tick(); while (!m_acc && !wd);
    req_op = 4'd9;
    do tick(); while (!m_acc && !wd);
    req_valid = 1'b0;
    settle();
    chk(cap.size() == 2 && cap[0].d == 'hB0 && cap[1].d == 'h30, "R7", "suspend resume", cap.size(), 2);

    run(12, 0, 0, 0);                      // R10 unknown op
    chk(cap.size() == 0, "R10", "unknown op writes", cap.size(), 0);
    run(15, 0, 0, 1);
    chk(cap.size() == 0, "R10", "unknown op writes", cap.size(), 0);

    repeat (4) tick();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule